// File: doc/BRIEF.md
# Delayed Read Target Responder

This block is the target side of one bridge port for reads that cannot be answered at once. The first time an initiator issues such a read, the block takes a copy of the request. It records the address, bus command and parity from the address phase, and the byte enables from the first cycle in which the initiator is ready. The block pushes that copy into the request queue toward the far bus and ends the bus cycle with a retry. The initiator keeps repeating the read. Each repeat is compared with the head of the read-completion queue. When the data is there and posted-write ordering allows, the words are streamed back one per ready cycle, and a disconnect goes out with the last one.

The block keeps a small table of the requests it has queued and not yet served. A repeated read that is already in that table is retried without a second enqueue. When the table is full, a new read is retried and dropped. For matching, the three memory-read commands are treated as one command; I/O reads must match exactly. If the initiator stops before taking the whole completion, the block pops and throws away the rest of that completion. Bus control signals are active low. Parity is even over AD, C/BE and PAR, and all three are presented together in the address phase.

Top module: `dlyrd_target`

## Requirements
- R1: After reset, devsel_n, trdy_n and stop_n are 1, ad_oe, req_valid, cpl_pop and perr_flag are 0.
- R2: A read (command 0010, 0110, 1100 or 1110 on cbe_n in the address phase) is claimed with devsel_n=0 from the cycle after the address phase. A read that is new is enqueued: req_valid is high for exactly one cycle after the first cycle with irdy_n=0. At that point req_addr and req_cmd carry the values from the address phase, and req_be carries cbe_n from that first ready cycle.
- R3: An attempt that delivers no data is ended with a retry, stop_n=0 with trdy_n=1. A repeat of a read that is still pending is retried without a new enqueue.
- R4: When the completion head matches but order_ok is 0 at the decision cycle, the attempt is retried and nothing is popped.
- R5: When the completion head matches (same address and matching command) and order_ok is 1, the block drives ad_oe=1, trdy_n=0 and ad_out equal to the head word. It pops one word on each cycle in which irdy_n is 0, so the words come out in queue order.
- R6: stop_n is 0 in the same cycle as trdy_n=0 with the word flagged cpl_last, and only then during delivery. After that transfer the block holds the stop until frame_n is released.
- R7: Memory read 0110, memory read line 1110 and memory read multiple 1100 match one another. An I/O read 0010 matches only 0010, so an I/O read and a memory read at one address are separate requests.
- R8: If the initiator's final data phase comes before the cpl_last word, the block pops the remaining words of that completion up to and including cpl_last without claiming the bus. It then frees the pending entry, so a later identical read is enqueued anew.
- R9: With PEND_DEPTH requests pending, a read that matches none of them is retried with no enqueue.
- R10: If the address phase fails even parity (XOR of ad_in, cbe_n and par is 1), the request is still enqueued, with req_par_err=1, and perr_flag goes to 1 and stays there.
- R11: A non-read command (for example 0111) is not claimed: devsel_n stays 1 and nothing is enqueued.
- R12: A cycle with irdy_n=1 during delivery pops nothing, and trdy_n and ad_out hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | AD_W | Address/data bus as driven by the initiator |
| cbe_n | input | 4 | Command in the address phase, byte enables in data phases |
| par | input | 1 | Even parity over ad_in and cbe_n for the address phase |
| devsel_n | output | 1 | Target claims the cycle, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Retry or disconnect request, active low |
| ad_out | output | AD_W | Read data driven to the bus |
| ad_oe | output | 1 | Output enable for ad_out |
| req_valid | output | 1 | One-cycle enqueue strobe to the request queue |
| req_addr | output | AD_W | Enqueued address |
| req_cmd | output | 4 | Enqueued bus command |
| req_be | output | 4 | Enqueued first-data-phase byte enables (active low lanes) |
| req_par_err | output | 1 | Address parity failed for this request |
| cpl_valid | input | 1 | Read data queue has a word at its head |
| cpl_addr | input | AD_W | Address of the request the head word answers |
| cpl_cmd | input | 4 | Command of the request the head word answers |
| cpl_data | input | AD_W | Head data word |
| cpl_last | input | 1 | Head word is the final word of its completion |
| order_ok | input | 1 | All earlier posted writes have been delivered |
| cpl_pop | output | 1 | Remove the head word from the read data queue |
| perr_flag | output | 1 | Sticky address parity error status |

## Verification
The bench builds the block with AD_W=32 and PEND_DEPTH=4. With that depth, four outstanding requests fill the pending table, so the full-table retry is reached within a few bus cycles. The sequence also frees a slot through an early-terminated delivery and then refills that slot. The four-word completion covers a master wait state in mid-burst. The three-word completion is cut short after one word, which exercises the drain of the remaining words.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;

    localparam logic [3:0] CMD_IO_RD       = 4'b0010;
    localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
    localparam logic [3:0] KEY_MEM_ANY     = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RETRY,
        ST_DATA,
        ST_FLUSH,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic [3:0] cmd;
        logic [3:0] be;
        logic       perr;
    } cap_rec_t;

    function automatic logic is_mem_read(input logic [3:0] cmd);
        return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULT) || (cmd == CMD_MEM_RD_LINE);
    endfunction

    function automatic logic is_read_cmd(input logic [3:0] cmd);
        return is_mem_read(cmd) || (cmd == CMD_IO_RD);
    endfunction

    // Matching key: all memory-read flavours fold onto one code.
    function automatic logic [3:0] match_key(input logic [3:0] cmd);
        return is_mem_read(cmd) ? KEY_MEM_ANY : cmd;
    endfunction

endpackage

// File: rtl/dlyrd_parity.sv
module dlyrd_parity #(
    parameter int AD_W = 32
) (
    input  logic [AD_W-1:0] ad,
    input  logic [3:0]      cbe,
    input  logic            par,
    output logic            err
);
    // Even parity across the bus, the command lanes and the parity bit.
    assign err = (^ad) ^ (^cbe) ^ par;
endmodule

// File: rtl/dlyrd_pend_table.sv
module dlyrd_pend_table #(
    parameter int AD_W  = 32,
    parameter int DEPTH = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] look_addr,
    input  logic [3:0]      look_key,
    output logic            look_hit,
    output logic [IW-1:0]   look_idx,
    output logic            full,
    input  logic            alloc_en,
    input  logic [AD_W-1:0] alloc_addr,
    input  logic [3:0]      alloc_key,
    input  logic            free_en,
    input  logic [IW-1:0]   free_idx
);
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] match;
    logic [AD_W-1:0]  addr_q [DEPTH];
    logic [3:0]       key_q  [DEPTH];
    logic [IW-1:0]    free_slot;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            assign match[i] = vld[i] && (addr_q[i] == look_addr) && (key_q[i] == look_key);

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld[i] <= 1'b0;
                end else if (alloc_en && (free_slot == IW'(i))) begin
                    vld[i] <= 1'b1;
                end else if (free_en && (free_idx == IW'(i))) begin
                    vld[i] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (alloc_en && (free_slot == IW'(i))) begin
                    addr_q[i] <= alloc_addr;
                    key_q[i]  <= alloc_key;
                end
            end
        end
    endgenerate

    // Lowest-numbered match and lowest-numbered empty slot.
    always_comb begin
        look_idx  = '0;
        free_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) look_idx = IW'(i);
            if (!vld[i])  free_slot = IW'(i);
        end
    end

    assign look_hit = |match;
    assign full     = &vld;
endmodule

// File: rtl/dlyrd_target.sv
module dlyrd_target
    import dlyrd_pkg::*;
#(
    parameter int AD_W       = 32,
    parameter int PEND_DEPTH = 4,
    localparam int IW        = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic [AD_W-1:0] ad_in,
    input  logic [3:0]      cbe_n,
    input  logic            par,
    output logic            devsel_n,
    output logic            trdy_n,
    output logic            stop_n,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe,
    output logic            req_valid,
    output logic [AD_W-1:0] req_addr,
    output logic [3:0]      req_cmd,
    output logic [3:0]      req_be,
    output logic            req_par_err,
    input  logic            cpl_valid,
    input  logic [AD_W-1:0] cpl_addr,
    input  logic [3:0]      cpl_cmd,
    input  logic [AD_W-1:0] cpl_data,
    input  logic            cpl_last,
    input  logic            order_ok,
    output logic            cpl_pop,
    output logic            perr_flag
);
    tgt_state_e      state;
    logic [AD_W-1:0] cap_addr;
    cap_rec_t        cap;
    logic [IW-1:0]   cur_idx;

    logic            par_err_now;
    logic            pt_hit;
    logic [IW-1:0]   pt_idx;
    logic            pt_full;
    logic            head_hit;
    logic            decide;
    logic            deliver;
    logic            enqueue;
    logic            xfer;
    logic            free_en;

    dlyrd_parity #(.AD_W(AD_W)) u_par (
        .ad  (ad_in),
        .cbe (cbe_n),
        .par (par),
        .err (par_err_now)
    );

    dlyrd_pend_table #(.AD_W(AD_W), .DEPTH(PEND_DEPTH)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .look_addr  (cap_addr),
        .look_key   (match_key(cap.cmd)),
        .look_hit   (pt_hit),
        .look_idx   (pt_idx),
        .full       (pt_full),
        .alloc_en   (enqueue),
        .alloc_addr (cap_addr),
        .alloc_key  (match_key(cap.cmd)),
        .free_en    (free_en),
        .free_idx   (cur_idx)
    );

    // Decision taken in the first cycle the initiator is ready.
    assign decide   = (state == ST_WAIT) && !irdy_n;
    assign head_hit = cpl_valid && (cpl_addr == cap_addr)
                      && (match_key(cpl_cmd) == match_key(cap.cmd));
    assign deliver  = decide && head_hit && order_ok;
    assign enqueue  = decide && !head_hit && !pt_hit && !pt_full;

    assign xfer     = (state == ST_DATA) && cpl_valid && !irdy_n;
    assign cpl_pop  = xfer || ((state == ST_FLUSH) && cpl_valid);
    assign free_en  = cpl_pop && cpl_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cap_addr  <= '0;
            cap       <= '0;
            cur_idx   <= '0;
            perr_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!frame_n) begin
                        if (is_read_cmd(cbe_n)) begin
                            cap_addr <= ad_in;
                            cap.cmd  <= cbe_n;
                            cap.perr <= par_err_now;
                            if (par_err_now) perr_flag <= 1'b1;
                            state    <= ST_WAIT;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!irdy_n) begin
                        cap.be  <= cbe_n;
                        cur_idx <= pt_idx;
                        state   <= deliver ? ST_DATA : ST_RETRY;
                    end
                end
                ST_RETRY: begin
                    if (frame_n) state <= ST_IDLE;
                end
                ST_DATA: begin
                    if (xfer) begin
                        if (cpl_last) begin
                            state <= frame_n ? ST_IDLE : ST_RETRY;
                        end else if (frame_n) begin
                            state <= ST_FLUSH;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (cpl_valid && cpl_last) state <= ST_IDLE;
                end
                ST_SKIP: begin
                    if (frame_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request queue strobe and payload.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid   <= 1'b0;
            req_addr    <= '0;
            req_cmd     <= '0;
            req_be      <= '0;
            req_par_err <= 1'b0;
        end else begin
            req_valid <= enqueue;
            if (enqueue) begin
                req_addr    <= cap_addr;
                req_cmd     <= cap.cmd;
                req_be      <= cbe_n;
                req_par_err <= cap.perr;
            end
        end
    end

    // Bus-facing target signals, decoded from state.
    always_comb begin
        devsel_n = !((state == ST_WAIT) || (state == ST_RETRY) || (state == ST_DATA));
        trdy_n   = !((state == ST_DATA) && cpl_valid);
        stop_n   = !((state == ST_RETRY) || ((state == ST_DATA) && cpl_valid && cpl_last));
        ad_oe    = (state == ST_DATA);
        ad_out   = ad_oe ? cpl_data : '0;
    end
endmodule

// File: rtl/dlyrd_target_chk.sv
module dlyrd_target_chk (
    input logic clk,
    input logic rst,
    input logic irdy_n,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic ad_oe,
    input logic req_valid,
    input logic cpl_valid,
    input logic cpl_last,
    input logic cpl_pop,
    input logic order_ok,
    input logic perr_flag
);
    // R2: enqueue strobe lasts one cycle
    a_r2_req_single: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R3: a stop without driven data is a retry
    a_r3_retry_no_trdy: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && !ad_oe) |-> (trdy_n && !devsel_n));

    // R4: delivery only begins after ordering was clear
    a_r4_order_before_data: assert property (@(posedge clk) disable iff (rst)
        $rose(ad_oe) |-> $past(order_ok));

    // R5: a pop while driving data is a completed handshake
    a_r5_pop_is_handshake: assert property (@(posedge clk) disable iff (rst)
        (cpl_pop && ad_oe) |-> (!trdy_n && !irdy_n));

    // R6: the final buffered word carries the disconnect
    a_r6_disc_on_last: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && !trdy_n && cpl_valid && cpl_last) |-> !stop_n);

    // R8: draining pops happen without claiming the bus
    a_r8_flush_quiet: assert property (@(posedge clk) disable iff (rst)
        (cpl_pop && !ad_oe) |-> (devsel_n && trdy_n));

    // R10: the parity status never clears
    a_r10_perr_sticky: assert property (@(posedge clk) disable iff (rst)
        perr_flag |=> perr_flag);
endmodule

bind dlyrd_target dlyrd_target_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .irdy_n    (irdy_n),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .ad_oe     (ad_oe),
    .req_valid (req_valid),
    .cpl_valid (cpl_valid),
    .cpl_last  (cpl_last),
    .cpl_pop   (cpl_pop),
    .order_ok  (order_ok),
    .perr_flag (perr_flag)
);

// File: tb/dlyrd_target_tb_top.sv
`timescale 1ns/1ps
module dlyrd_target_tb_top;
    localparam int AD_W  = 32;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst;
    logic            frame_n, irdy_n, par;
    logic [AD_W-1:0] ad_in;
    logic [3:0]      cbe_n;
    logic            devsel_n, trdy_n, stop_n, ad_oe;
    logic [AD_W-1:0] ad_out;
    logic            req_valid, req_par_err;
    logic [AD_W-1:0] req_addr;
    logic [3:0]      req_cmd, req_be;
    logic            cpl_valid = 1'b0;
    logic [AD_W-1:0] cpl_addr = '0;
    logic [3:0]      cpl_cmd = '0;
    logic [AD_W-1:0] cpl_data = '0;
    logic            cpl_last = 1'b0;
    logic            order_ok;
    logic            cpl_pop, perr_flag;

    dlyrd_target #(.AD_W(AD_W), .PEND_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in),
        .cbe_n(cbe_n), .par(par), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .ad_out(ad_out), .ad_oe(ad_oe), .req_valid(req_valid),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be),
        .req_par_err(req_par_err), .cpl_valid(cpl_valid), .cpl_addr(cpl_addr),
        .cpl_cmd(cpl_cmd), .cpl_data(cpl_data), .cpl_last(cpl_last),
        .order_ok(order_ok), .cpl_pop(cpl_pop), .perr_flag(perr_flag)
    );

    typedef struct {
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic [31:0] data;
        bit          last;
    } cw_t;
    typedef struct {
        logic [31:0] addr;
        logic [3:0]  key;
    } pe_t;

    cw_t cq[$];   // model of the read data queue the bench serves
    pe_t mp[$];   // model of outstanding requests
    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    function automatic logic [3:0] kfold(input logic [3:0] c);
        return (c == 4'b0110 || c == 4'b1100 || c == 4'b1110) ? 4'hF : c;
    endfunction

    // Read data queue served by the bench: pops on cpl_pop, head shown after the edge.
    always @(posedge clk) begin
        if (cpl_pop && cq.size() > 0) cq.delete(0);
        if (cq.size() > 0) begin
            cpl_valid <= 1'b1;
            cpl_addr  <= cq[0].addr;
            cpl_cmd   <= cq[0].cmd;
            cpl_data  <= cq[0].data;
            cpl_last  <= cq[0].last;
        end else begin
            cpl_valid <= 1'b0;
            cpl_last  <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic push_cpl(input logic [31:0] a, input logic [3:0] c, input int n);
        for (int k = 0; k < n; k++)
            cq.push_back('{a, c, a ^ (32'h0101_0101 * (k + 1)), (k == n - 1)});
        repeat (2) @(negedge clk);
    endtask

    function automatic int find_pend(input logic [31:0] a, input logic [3:0] c);
        for (int i = 0; i < mp.size(); i++)
            if (mp[i].addr == a && mp[i].key == kfold(c)) return i;
        return -1;
    endfunction

    // One read attempt by the initiator; take = words to accept, ws_at = word with a wait state.
    task automatic rd(input string tag, input logic [31:0] a, input logic [3:0] cmd,
                      input logic [3:0] be, input bit badpar, input int take, input int ws_at);
        int  kind;
        int  pidx;
        int  sz0;
        cw_t words[$];
        pidx = find_pend(a, cmd);
        if (cq.size() > 0 && cq[0].addr == a && kfold(cq[0].cmd) == kfold(cmd) && order_ok)
            kind = 2;
        else if (pidx >= 0 || mp.size() >= DEPTH)
            kind = 1;
        else
            kind = 0;
        if (kind == 2) begin
            for (int i = 0; i < cq.size(); i++) begin
                words.push_back(cq[i]);
                if (cq[i].last) break;
            end
        end
        sz0 = cq.size();

        @(negedge clk);
        frame_n = 1'b0; ad_in = a; cbe_n = cmd; par = (^a) ^ (^cmd) ^ badpar;
        @(negedge clk);
        chk(devsel_n == 1'b0, "R2", "claim after address phase", 32'(devsel_n), 0);
        chk(stop_n && trdy_n, "R2", "no early response", {stop_n, trdy_n}, 32'h3);
        cbe_n = be; irdy_n = 1'b0; ad_in = '0;
        @(negedge clk);
        chk(req_valid == (kind == 0), tag, "enqueue strobe", 32'(req_valid), 32'(kind == 0));
        if (kind == 0) begin
            chk(req_addr == a, "R2", "req_addr", req_addr, a);
            chk(req_cmd == cmd, "R2", "req_cmd", 32'(req_cmd), 32'(cmd));
            chk(req_be == be, "R2", "req_be", 32'(req_be), 32'(be));
            chk(req_par_err == badpar, "R10", "req_par_err", 32'(req_par_err), 32'(badpar));
            mp.push_back('{a, kfold(cmd)});
        end
        if (kind != 2) begin
            chk(!stop_n && trdy_n, "R3", "retry shape", {stop_n, trdy_n}, 32'h1);
            chk(ad_oe == 1'b0, tag, "no data driven on retry", 32'(ad_oe), 0);
            frame_n = 1'b1;
            @(negedge clk);
            irdy_n = 1'b1;
            chk(devsel_n && stop_n, "R3", "release after retry", {devsel_n, stop_n}, 32'h3);
            chk(cq.size() == sz0, tag, "nothing popped on retry", cq.size(), sz0);
        end else begin
            int k;
            for (k = 0; k < words.size(); k++) begin
                if (k == ws_at) begin
                    irdy_n = 1'b1;
                    @(negedge clk);
                    chk(trdy_n == 1'b0 && ad_out == words[k].data, "R12", "hold in wait state",
                        ad_out, words[k].data);
                    chk(cq.size() == sz0 - k, "R12", "no pop in wait state", cq.size(), sz0 - k);
                    irdy_n = 1'b0;
                end
                chk(trdy_n == 1'b0 && ad_oe == 1'b1, "R5", "target ready with data",
                    {trdy_n, ad_oe}, 32'h1);
                chk(ad_out == words[k].data, "R5", "data word", ad_out, words[k].data);
                chk(stop_n == !words[k].last, "R6", "disconnect only with last word",
                    32'(stop_n), 32'(!words[k].last));
                if (k == take - 1 && !words[k].last) frame_n = 1'b1;
                @(negedge clk);
                if (k == take - 1) break;
            end
            if (take >= words.size()) begin
                chk(!stop_n && trdy_n && !devsel_n, "R6", "stop held after last word",
                    {devsel_n, stop_n, trdy_n}, 32'h1);
                chk(cq.size() == sz0 - words.size(), "R5", "one pop per word",
                    cq.size(), sz0 - words.size());
                frame_n = 1'b1;
                @(negedge clk);
                irdy_n = 1'b1;
            end else begin
                irdy_n = 1'b1;
                repeat (words.size() + 2) begin
                    @(negedge clk);
                    chk(devsel_n == 1'b1, "R8", "no claim while draining", 32'(devsel_n), 1);
                end
                chk(cq.size() == sz0 - words.size(), "R8", "leftover words discarded",
                    cq.size(), sz0 - words.size());
            end
            if (pidx >= 0) mp.delete(pidx);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
        par = 1'b0; order_ok = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(devsel_n && trdy_n && stop_n, "R1", "bus signals idle",
            {devsel_n, trdy_n, stop_n}, 32'h7);
        chk(!ad_oe && !req_valid && !cpl_pop && !perr_flag, "R1", "strobes low",
            {ad_oe, req_valid, cpl_pop, perr_flag}, 0);

        // New I/O read, then a repeat before the data exists.
        rd("R2", 32'h0000_0100, 4'b0010, 4'b0101, 0, 99, -1);
        rd("R3", 32'h0000_0100, 4'b0010, 4'b0101, 0, 99, -1);

        // Completion present but ordering blocked, then allowed.
        push_cpl(32'h0000_0100, 4'b0010, 1);
        order_ok = 1'b0;
        rd("R4", 32'h0000_0100, 4'b0010, 4'b0000, 0, 99, -1);
        order_ok = 1'b1;
        rd("R5", 32'h0000_0100, 4'b0010, 4'b0000, 0, 99, -1);

        // Memory-read aliasing and a burst with a master wait state.
        rd("R2", 32'h0000_0200, 4'b0110, 4'b0000, 0, 99, -1);
        rd("R7", 32'h0000_0200, 4'b1100, 4'b0000, 0, 99, -1);
        push_cpl(32'h0000_0200, 4'b0110, 4);
        rd("R7", 32'h0000_0200, 4'b1110, 4'b0000, 0, 99, 1);

        // I/O and memory reads at one address are separate requests.
        rd("R2", 32'h0000_0300, 4'b0010, 4'b1110, 0, 99, -1);
        rd("R7", 32'h0000_0300, 4'b0110, 4'b0000, 0, 99, -1);

        // Early termination drains the rest and frees the entry.
        push_cpl(32'h0000_0300, 4'b1100, 3);
        rd("R8", 32'h0000_0300, 4'b0110, 4'b0000, 0, 1, -1);
        rd("R8", 32'h0000_0300, 4'b1110, 4'b0000, 0, 99, -1);

        // Fill the table, then one more distinct read.
        rd("R2", 32'h0000_0400, 4'b0110, 4'b0000, 0, 99, -1);
        rd("R2", 32'h0000_0500, 4'b0110, 4'b0000, 0, 99, -1);
        rd("R9", 32'h0000_0600, 4'b0110, 4'b0000, 0, 99, -1);
        chk(perr_flag == 1'b0, "R10", "flag clear with good parity", 32'(perr_flag), 0);

        // Free one slot, then a request with bad address parity.
        push_cpl(32'h0000_0300, 4'b0010, 1);
        rd("R5", 32'h0000_0300, 4'b0010, 4'b0000, 0, 99, -1);
        rd("R10", 32'h0000_0700, 4'b0110, 4'b0011, 1, 99, -1);
        chk(perr_flag == 1'b1, "R10", "flag set", 32'(perr_flag), 1);
        repeat (3) @(negedge clk);
        chk(perr_flag == 1'b1, "R10", "flag sticky", 32'(perr_flag), 1);

        // A write command is not claimed.
        @(negedge clk);
        frame_n = 1'b0; ad_in = 32'h0000_0800; cbe_n = 4'b0111; par = (^ad_in) ^ (^cbe_n);
        @(negedge clk);
        chk(devsel_n == 1'b1 && req_valid == 1'b0, "R11", "write not claimed",
            {devsel_n, req_valid}, 32'h2);
        irdy_n = 1'b0; cbe_n = 4'b0000;
        @(negedge clk);
        chk(devsel_n == 1'b1 && stop_n == 1'b1, "R11", "still unclaimed",
            {devsel_n, stop_n}, 32'h3);
        frame_n = 1'b1;
        @(negedge clk);
        irdy_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0 && devsel_n == 1'b1, "R11", "no enqueue after write",
            {req_valid, devsel_n}, 32'h1);

        done = 1;
        finish_run();
    end
endmodule